// File: doc/BRIEF.md
# Tach Period Speed Discriminator

This block judges motor speed from a tachometer pulse train. A reference tick, supplied by a separate frequency multiplier running at 512 times the commanded rate, is counted across each tach period. When the motor turns at exactly the commanded rate, one tach period holds 512 ticks. At every tach rising edge the count of the period just ended is classified as one of three verdicts: in-lock, too slow (accelerate) or too fast (decelerate). The magnitude of the error is reported with it, so a downstream integrator can turn the verdict into a drive command.

The tach input may be asynchronous. It passes through a two-flop synchronizer and a rising-edge detector. A small state machine has two states. `ST_ARMING` is entered from reset. Its only transition, `ARM_TO_TRACK`, fires on the first tach edge, and the partial period before that edge is thrown away. `ST_TRACKING` then loops on itself through `TRACK_EVAL` at each later edge, and each such edge publishes one result. The period counter saturates, so a very slow or stalled motor reads as maximally slow once an edge finally arrives.

Top module: `speed_discriminator`

## Requirements
- R1: While `rst_n` is low and on release, `lock_n`=1, `accel`=0, `decel`=0, `err_mag`=0 and `result_valid`=0.
- R2: The first tach rising edge after reset produces no result: `result_valid` stays 0 and all outputs keep their reset values.
- R3: The period count equals the number of cycles with `ref_tick`=1 between consecutive tach rising edges. It is published as a one-cycle `result_valid` pulse, visible after the third rising clock edge following the tach rise.
- R4: A count from 480 to 544 inclusive gives `lock_n`=0, `accel`=0, `decel`=0.
- R5: A count above 544 gives `accel`=1, `decel`=0, `lock_n`=1.
- R6: A count below 480 gives `decel`=1, `accel`=0, `lock_n`=1.
- R7: `err_mag` equals the absolute difference between the count and 512.
- R8: The counter saturates at 1023 (all ones), so a longer period yields `accel`=1 and `err_mag`=511.
- R9: Without a tach edge, no result is produced and all outputs hold their values, however long the tach stays idle.
- R10: `accel` and `decel` are never both 1, and `lock_n`=0 never coincides with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Raw tach pulse train, asynchronous |
| ref_tick | input | 1 | Reference count enable, one per reference period |
| lock_n | output | 1 | Low while the last period was inside the lock window |
| accel | output | 1 | Last period too long: speed up |
| decel | output | 1 | Last period too short: slow down |
| err_mag | output | 10 | Absolute count error against 512 |
| result_valid | output | 1 | One-cycle pulse when a new verdict is published |

## Verification
The bench targets both window edges (479, 480, 544 and 545 ticks). An off-by-one comparison would flip lock at exactly one of these counts, and an asymmetric error calculation would show 32 or 33 on the wrong side. A stalled period longer than the counter range checks saturation: a wrapping counter would report a small count and falsely decelerate or lock. The discarded first period after reset and a long idle gap both check that nothing is published without a measured period. A reference that ticks every other cycle catches a counter that counts clocks instead of ticks.

// File: rtl/spd_disc_pkg.sv
package spd_disc_pkg;

    typedef enum logic [0:0] {
        ST_ARMING   = 1'b0,
        ST_TRACKING = 1'b1
    } disc_state_t;

    typedef enum logic [1:0] {
        VD_LOCKED = 2'd0,
        VD_SLOW   = 2'd1,
        VD_FAST   = 2'd2
    } verdict_t;

endpackage

// File: rtl/spd_tach_sync.sv
module spd_tach_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    output logic tach_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], tach_raw};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tach_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/spd_period_ctr.sv
module spd_period_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] period_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_cnt <= '0;
        end else if (restart) begin
            period_cnt <= tick ? CNT_W'(1) : '0;
        end else if (tick && (period_cnt != CNT_MAX)) begin
            period_cnt <= period_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spd_verdict_fsm.sv
module spd_verdict_fsm
    import spd_disc_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int TARGET = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_rise,
    input  logic [CNT_W-1:0] period_cnt,
    output logic             lock_n,
    output logic             accel,
    output logic             decel,
    output logic [CNT_W-1:0] err_mag,
    output logic             result_valid
);
    localparam int               WINDOW = TARGET / 16;
    localparam logic [CNT_W-1:0] TGT    = CNT_W'(TARGET);
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(TARGET - WINDOW);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(TARGET + WINDOW);

    disc_state_t      state_q, state_d;
    verdict_t         verdict;
    logic [CNT_W-1:0] err_now;
    logic             evaluate;

    // classification of the period that just ended
    always_comb begin
        if (period_cnt > LIM_HI)      verdict = VD_SLOW;
        else if (period_cnt < LIM_LO) verdict = VD_FAST;
        else                          verdict = VD_LOCKED;
        err_now = (period_cnt >= TGT) ? (period_cnt - TGT) : (TGT - period_cnt);
    end

    // next state: ARM_TO_TRACK on first edge, TRACK_EVAL loops
    always_comb begin
        state_d  = state_q;
        evaluate = 1'b0;
        unique case (state_q)
            ST_ARMING: begin
                if (tach_rise) state_d = ST_TRACKING;
            end
            ST_TRACKING: begin
                if (tach_rise) evaluate = 1'b1;
            end
            default: state_d = ST_ARMING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMING;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_n       <= 1'b1;
            accel        <= 1'b0;
            decel        <= 1'b0;
            err_mag      <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= evaluate;
            if (evaluate) begin
                err_mag <= err_now;
                unique case (verdict)
                    VD_LOCKED: begin
                        lock_n <= 1'b0; accel <= 1'b0; decel <= 1'b0;
                    end
                    VD_SLOW: begin
                        lock_n <= 1'b1; accel <= 1'b1; decel <= 1'b0;
                    end
                    VD_FAST: begin
                        lock_n <= 1'b1; accel <= 1'b0; decel <= 1'b1;
                    end
                    default: begin
                        lock_n <= 1'b1; accel <= 1'b0; decel <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/speed_discriminator.sv
module speed_discriminator #(
    parameter int TARGET = 512,
    parameter int CNT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_in,
    input  logic             ref_tick,
    output logic             lock_n,
    output logic             accel,
    output logic             decel,
    output logic [CNT_W-1:0] err_mag,
    output logic             result_valid
);
    logic             tach_rise;
    logic [CNT_W-1:0] period_cnt;

    spd_tach_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tach_raw  (tach_in),
        .tach_rise (tach_rise)
    );

    spd_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (tach_rise),
        .tick       (ref_tick),
        .period_cnt (period_cnt)
    );

    spd_verdict_fsm #(.CNT_W(CNT_W), .TARGET(TARGET)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tach_rise    (tach_rise),
        .period_cnt   (period_cnt),
        .lock_n       (lock_n),
        .accel        (accel),
        .decel        (decel),
        .err_mag      (err_mag),
        .result_valid (result_valid)
    );
endmodule

// File: rtl/spd_disc_checker.sv
module spd_disc_checker #(
    parameter int TARGET = 512,
    parameter int CNT_W  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_n,
    input logic             accel,
    input logic             decel,
    input logic [CNT_W-1:0] err_mag,
    input logic             result_valid
);
    localparam logic [CNT_W-1:0] WIN = CNT_W'(TARGET / 16);

    // R10
    excl_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accel && decel));
    // R10
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n |-> (!accel && !decel));
    // R4
    lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n |-> (err_mag <= WIN));
    // R5
    accel_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accel |-> (err_mag > WIN));
    // R6
    decel_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decel |-> (err_mag > WIN));
    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R9
    hold_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(err_mag));
    // R9
    hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(lock_n));
endmodule

bind speed_discriminator spd_disc_checker #(.TARGET(TARGET), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_n       (lock_n),
    .accel        (accel),
    .decel        (decel),
    .err_mag      (err_mag),
    .result_valid (result_valid)
);

// File: tb/speed_discriminator_test.sv
`timescale 1ns/1ps
module speed_discriminator_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tach_in = 1'b0;
    logic       ref_tick = 1'b0;
    logic       lock_n, accel, decel, result_valid;
    logic [9:0] err_mag;

    int errors = 0;
    int checks = 0;
    int vcount = 0;
    int tick_div = 1;
    int phase = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    speed_discriminator uut (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ref_tick(ref_tick),
        .lock_n(lock_n), .accel(accel), .decel(decel),
        .err_mag(err_mag), .result_valid(result_valid)
    );

    always @(negedge clk) begin
        phase <= phase + 1;
        ref_tick <= ((phase % tick_div) == 0);
        if (result_valid) vcount <= vcount + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one tach period of p cycles starting with a rise
    task automatic tach_period(input int p);
        @(negedge clk) tach_in = 1'b1;
        repeat (p/2) @(negedge clk);
        tach_in = 1'b0;
        repeat (p - p/2 - 1) @(negedge clk);
    endtask

    // closing rise, then check the verdict for the measured period
    task automatic close_and_check(input string req, input bit e_lockn, input bit e_acc,
                                   input bit e_dec, input int e_err);
        int v0;
        v0 = vcount;
        @(negedge clk) tach_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(vcount == v0 + 1, {req, " R3 one result"}, vcount - v0, 1);
        chk(lock_n == e_lockn, {req, " lock_n"}, lock_n, e_lockn);
        chk(accel == e_acc, {req, " accel"}, accel, e_acc);
        chk(decel == e_dec, {req, " decel"}, decel, e_dec);
        chk(err_mag == e_err, {req, " R7 err_mag"}, err_mag, e_err);
        tach_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic measure(input int p, input int div, input string req, input bit e_lockn,
                           input bit e_acc, input bit e_dec, input int e_err);
        tick_div = div;
        repeat (4) @(negedge clk);
        tach_period(p);
        close_and_check(req, e_lockn, e_acc, e_dec, e_err);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(lock_n == 1'b1, "R1 lock_n", lock_n, 1);
        chk(accel == 1'b0, "R1 accel", accel, 0);
        chk(decel == 1'b0, "R1 decel", decel, 0);
        chk(err_mag == 0, "R1 err_mag", err_mag, 0);
        chk(result_valid == 1'b0, "R1 valid", result_valid, 0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        tach_in = 1'b1;
        repeat (8) @(negedge clk);
        tach_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(vcount == 0, "R2 no result on first edge", vcount, 0);
        chk(lock_n == 1'b1 && err_mag == 0, "R2 outputs kept", err_mag, 0);
    endtask

    task automatic test_stall();
        int v0;
        bit l0;
        int e0;
        v0 = vcount; l0 = lock_n; e0 = err_mag;
        repeat (1500) @(negedge clk);
        chk(vcount == v0, "R9 no result while idle", vcount, v0);
        chk(lock_n == l0 && err_mag == e0, "R9 outputs hold", err_mag, e0);
        // interval since last rise exceeds 1023 ticks
        close_and_check("R8 saturated", 1'b1, 1'b1, 1'b0, 511);
    endtask

    initial begin
        test_reset();
        measure(512, 1, "R4 nominal", 1'b0, 1'b0, 1'b0, 0);
        measure(480, 1, "R4 low edge", 1'b0, 1'b0, 1'b0, 32);
        measure(544, 1, "R4 high edge", 1'b0, 1'b0, 1'b0, 32);
        measure(545, 1, "R5 slow", 1'b1, 1'b1, 1'b0, 33);
        measure(479, 1, "R6 fast", 1'b1, 1'b0, 1'b1, 33);
        measure(1024, 2, "R3 half-rate ticks", 1'b0, 1'b0, 1'b0, 0);
        measure(1090, 2, "R5 half-rate slow", 1'b1, 1'b1, 1'b0, 33);
        measure(400, 1, "R6 far fast", 1'b1, 1'b0, 1'b1, 112);
        measure(1100, 1, "R8 long period", 1'b1, 1'b1, 1'b0, 511);
        measure(500, 1, "R10 relock", 1'b0, 1'b0, 1'b0, 12);
        test_stall();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule